// File: doc/BRIEF.md
# Serial flash command frame decoder

This block is the serial front end of a page-oriented flash memory model. It watches a mode-0 SPI bus (clock idle low, data sampled on the rising clock edge, most significant bit first). It oversamples the serial clock, chip select and data line with the system clock. While chip select is low it collects one command frame: an 8-bit opcode followed by a 24-bit address field.

When chip select returns high after exactly 32 bits, the opcode is decoded into one of three page operations: load a buffer from memory, compare memory with a buffer, or rewrite a page through a buffer. The opcode also names one of two buffers. The page number is taken from the address field. The block then raises a single-cycle launch pulse with the operation, buffer and page beside it.

Frames of the wrong length and unknown opcodes are dropped without any output. A good frame that ends while the downstream engine reports busy is also dropped, and this raises a one-cycle error flag instead of the launch pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `launch`, `busy_reject`, `launch_op`, `launch_buf` and `launch_page` are all zero.
- R2: The opcode selects operation and buffer: 0x53 → op 1 (load from memory), buffer 0; 0x55 → op 1, buffer 1; 0x60 → op 2 (compare), buffer 0; 0x61 → op 2, buffer 1; 0x58 → op 3 (rewrite), buffer 0; 0x59 → op 3, buffer 1.
- R3: `launch_page` equals bits 18..9 of the 24-bit address field (the field is sent MSB first as 5 ignored bits, then the 10-bit page, then 9 ignored bits). The ignored bits have no effect on any output.
- R4: No launch occurs while chip select is low, even after all 32 bits have arrived. The launch follows only the rise of chip select.
- R5: A frame that ends with any bit count other than 32 (0, 31 and 33 included) produces neither `launch` nor `busy_reject`.
- R6: A 32-bit frame whose opcode is not one of the six in R2 produces neither `launch` nor `busy_reject`, whether or not the engine is busy.
- R7: A valid 32-bit frame that ends while `engine_busy` is high produces no launch and raises `busy_reject` for exactly one cycle.
- R8: Each accepted frame yields exactly one `launch` pulse, one clock cycle wide. The operation, buffer and page are valid in that cycle.
- R9: Serial clock edges that occur while chip select is high shift in nothing, and they do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| engine_busy | input | 1 | Downstream operation engine is busy |
| launch | output | 1 | One-cycle start strobe for an accepted command |
| launch_op | output | 2 | Operation: 1 load, 2 compare, 3 rewrite |
| launch_buf | output | 1 | Buffer select: 0 first, 1 second |
| launch_page | output | 10 | Page number of the command |
| busy_reject | output | 1 | One-cycle flag: valid frame dropped because engine busy |

## Verification
Two events can meet in the same clock cycle: the end of a frame (chip select rising after 32 bits) and the busy indication from the engine. The bench holds `engine_busy` high across the whole frame and the chip select rise, for both a valid opcode and an unknown one. It then counts `launch` and `busy_reject` pulses in a window after the rise: a valid opcode must give exactly one reject and no launch, and an unknown opcode must give neither. The same opcodes with busy low must launch normally, which shows that the rejection comes from busy alone.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_LOAD    = 2'd1,
    OP_COMPARE = 2'd2,
    OP_REWRITE = 2'd3
  } page_op_e;

  typedef struct packed {
    logic     known;
    page_op_e op;
    logic     buf_sel;
  } cmd_decode_t;

  // Map an opcode onto operation and buffer; unknown codes give known=0.
  function automatic cmd_decode_t decode_opcode(input logic [7:0] opc);
    cmd_decode_t d;
    d = '{known: 1'b1, op: OP_NONE, buf_sel: 1'b0};
    case (opc)
      8'h53: begin d.op = OP_LOAD;    d.buf_sel = 1'b0; end
      8'h55: begin d.op = OP_LOAD;    d.buf_sel = 1'b1; end
      8'h60: begin d.op = OP_COMPARE; d.buf_sel = 1'b0; end
      8'h61: begin d.op = OP_COMPARE; d.buf_sel = 1'b1; end
      8'h58: begin d.op = OP_REWRITE; d.buf_sel = 1'b0; end
      8'h59: begin d.op = OP_REWRITE; d.buf_sel = 1'b1; end
      default: d.known = 1'b0;
    endcase
    return d;
  endfunction

  // Next value of a saturating bit counter.
  function automatic int unsigned next_count(input int unsigned cur, input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import flash_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int OPC_BITS   = 8,
  parameter int PAGE_BITS  = 10,
  parameter int PAGE_LSB   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_pin,
  input  logic                 cs_n_pin,
  input  logic                 mosi_pin,
  output logic                 frame_end,
  output logic                 frame_full,
  output logic [OPC_BITS-1:0]  frame_opc,
  output logic [PAGE_BITS-1:0] frame_page
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic sck_s, cs_s, mosi_s;
  logic sck_d, cs_d;
  logic sck_rise, cs_rise;
  logic [FRAME_BITS-1:0] shift_q;
  logic [CNT_W-1:0]      count_q;

  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck  (.clk(clk), .rst_n(rst_n), .d_async(sck_pin),  .q_sync(sck_s));
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs   (.clk(clk), .rst_n(rst_n), .d_async(cs_n_pin), .q_sync(cs_s));
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (.clk(clk), .rst_n(rst_n), .d_async(mosi_pin), .q_sync(mosi_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign cs_rise  = cs_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      count_q <= '0;
    end else if (cs_s) begin
      count_q <= '0;
    end else if (sck_rise) begin
      shift_q <= {shift_q[FRAME_BITS-2:0], mosi_s};
      count_q <= CNT_W'(next_count(int'(count_q), CNT_MAX));
    end
  end

  assign frame_end  = cs_rise;
  assign frame_full = (count_q == CNT_W'(FRAME_BITS));
  assign frame_opc  = shift_q[FRAME_BITS-1 -: OPC_BITS];
  assign frame_page = shift_q[PAGE_LSB +: PAGE_BITS];

  // R9: no capture while chip select is deasserted
  assert_idle_no_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(shift_q));

  // R5: the count never passes its saturation value
  assert_count_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/cmd_launch.sv
module cmd_launch
  import flash_cmd_pkg::*;
#(
  parameter int OPC_BITS  = 8,
  parameter int PAGE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_end,
  input  logic                 frame_full,
  input  logic [OPC_BITS-1:0]  frame_opc,
  input  logic [PAGE_BITS-1:0] frame_page,
  input  logic                 engine_busy,
  output logic                 launch,
  output logic [1:0]           launch_op,
  output logic                 launch_buf,
  output logic [PAGE_BITS-1:0] launch_page,
  output logic                 busy_reject
);
  cmd_decode_t dec;
  logic        accept_ok;

  assign dec       = decode_opcode(frame_opc);
  assign accept_ok = frame_end & frame_full & dec.known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch      <= 1'b0;
      busy_reject <= 1'b0;
      launch_op   <= '0;
      launch_buf  <= 1'b0;
      launch_page <= '0;
    end else begin
      launch      <= accept_ok & ~engine_busy;
      busy_reject <= accept_ok & engine_busy;
      if (accept_ok && !engine_busy) begin
        launch_op   <= dec.op;
        launch_buf  <= dec.buf_sel;
        launch_page <= frame_page;
      end
    end
  end

  // R4: a launch always follows a chip select rise
  assert_launch_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(frame_end));

  // R5: a launch needs a full-length frame
  assert_launch_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(frame_full));

  // R7: busy suppresses the launch and launch never meets reject
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !$past(engine_busy));
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && busy_reject));

  // R8: single-cycle pulse with a real operation
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
  assert_valid_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (launch_op != 2'd0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int OPC_BITS    = 8,
  parameter int PAGE_BITS   = 10,
  parameter int PAGE_LSB    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  input  logic                 engine_busy,
  output logic                 launch,
  output logic [1:0]           launch_op,
  output logic                 launch_buf,
  output logic [PAGE_BITS-1:0] launch_page,
  output logic                 busy_reject
);
  logic                 frame_end;
  logic                 frame_full;
  logic [OPC_BITS-1:0]  frame_opc;
  logic [PAGE_BITS-1:0] frame_page;

  frame_shifter #(
    .FRAME_BITS(FRAME_BITS), .OPC_BITS(OPC_BITS), .PAGE_BITS(PAGE_BITS),
    .PAGE_LSB(PAGE_LSB), .SYNC_STAGES(SYNC_STAGES)
  ) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_pin(spi_sck), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
    .frame_end(frame_end), .frame_full(frame_full),
    .frame_opc(frame_opc), .frame_page(frame_page)
  );

  cmd_launch #(.OPC_BITS(OPC_BITS), .PAGE_BITS(PAGE_BITS)) u_launch (
    .clk(clk), .rst_n(rst_n),
    .frame_end(frame_end), .frame_full(frame_full),
    .frame_opc(frame_opc), .frame_page(frame_page),
    .engine_busy(engine_busy),
    .launch(launch), .launch_op(launch_op), .launch_buf(launch_buf),
    .launch_page(launch_page), .busy_reject(busy_reject)
  );

  // R7: a reject pulse lasts a single cycle
  assert_reject_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_reject |=> !busy_reject);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic launch, launch_buf, busy_reject;
  logic [1:0] launch_op;
  logic [9:0] launch_page;

  int n_vec = 0, n_bad = 0;
  int n_launch = 0, n_rej = 0;
  logic prev_launch = 1'b0, wide_pulse = 1'b0;
  logic [1:0] cap_op;
  logic cap_buf;
  logic [9:0] cap_page;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .engine_busy(busy), .launch(launch), .launch_op(launch_op),
    .launch_buf(launch_buf), .launch_page(launch_page), .busy_reject(busy_reject)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (launch) begin
        n_launch++;
        cap_op = launch_op; cap_buf = launch_buf; cap_page = launch_page;
        if (prev_launch) wide_pulse = 1'b1;
      end
      if (busy_reject) n_rej++;
      prev_launch = launch;
    end
  end

  typedef struct packed {
    logic [7:0]  opc;
    logic [9:0]  page;
    logic [5:0]  nbits;
    logic        busy;
    logic        exp_launch;
    logic [1:0]  exp_op;
    logic        exp_buf;
    logic        exp_rej;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h53, 10'h000, 6'd32, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0},
    '{8'h55, 10'h3FF, 6'd32, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0},
    '{8'h60, 10'h155, 6'd32, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},
    '{8'h61, 10'h2AA, 6'd32, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0},
    '{8'h58, 10'h001, 6'd32, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0},
    '{8'h59, 10'h200, 6'd32, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0},
    '{8'h53, 10'h0F0, 6'd31, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h60, 10'h0F0, 6'd33, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h54, 10'h123, 6'd32, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h59, 10'h0AB, 6'd32, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
    '{8'h00, 10'h0AB, 6'd32, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h61, 10'h0AB, 6'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send nbits of {opc, addr}, MSB first; rising sck samples.
  task automatic send_frame(input logic [7:0] opc, input logic [23:0] addr, input int nbits);
    logic [31:0] word;
    int l0;
    word = {opc, addr};
    cs_n = 1'b0;
    clocks(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? word[31-i] : 1'b0;
      clocks(3);
      sck = 1'b1;
      clocks(3);
      sck = 1'b0;
    end
    l0 = n_launch;
    clocks(8);
    if (nbits == 32) check("R4 no launch before cs rise", n_launch == l0, n_launch - l0, 0);
    cs_n = 1'b1;
    clocks(10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int l0, r0;
    clocks(3);
    // R1: reset state
    check("R1 launch", launch == 1'b0, launch, 0);
    check("R1 reject", busy_reject == 1'b0, busy_reject, 0);
    check("R1 payload", {launch_op, launch_buf, launch_page} == '0,
          {launch_op, launch_buf, launch_page}, 0);
    rst_n = 1'b1;
    clocks(3);

    for (int v = 0; v < NV; v++) begin
      busy = VECS[v].busy;
      l0 = n_launch; r0 = n_rej;
      // ignored reserved and trailing bits set to ones (R3)
      send_frame(VECS[v].opc, {5'b11111, VECS[v].page, 9'h1FF}, int'(VECS[v].nbits));
      check($sformatf("R2/R5/R6 launch count vec %0d", v),
            (n_launch - l0) == int'(VECS[v].exp_launch), n_launch - l0, VECS[v].exp_launch);
      check($sformatf("R7 reject count vec %0d", v),
            (n_rej - r0) == int'(VECS[v].exp_rej), n_rej - r0, VECS[v].exp_rej);
      if (VECS[v].exp_launch) begin
        check($sformatf("R2 op vec %0d", v), cap_op == VECS[v].exp_op, cap_op, VECS[v].exp_op);
        check($sformatf("R2 buf vec %0d", v), cap_buf == VECS[v].exp_buf, cap_buf, VECS[v].exp_buf);
        check($sformatf("R3 page vec %0d", v), cap_page == VECS[v].page, cap_page, VECS[v].page);
      end
      busy = 1'b0;
      clocks(2);
    end

    // R3: reserved and trailing bits zero give the same page
    l0 = n_launch;
    send_frame(8'h58, {5'b00000, 10'h2C3, 9'h000}, 32);
    check("R3 page zero fill", (n_launch - l0) == 1 && cap_page == 10'h2C3, cap_page, 10'h2C3);

    // R9: sck toggles while cs high are ignored
    for (int k = 0; k < 7; k++) begin
      mosi = k[0];
      clocks(3); sck = 1'b1; clocks(3); sck = 1'b0;
    end
    l0 = n_launch;
    send_frame(8'h55, {5'b0, 10'h19C, 9'h0}, 32);
    check("R9 count after idle sck", (n_launch - l0) == 1, n_launch - l0, 1);
    check("R9 page after idle sck", cap_page == 10'h19C, cap_page, 10'h19C);
    check("R9 op after idle sck", cap_op == 2'd1 && cap_buf == 1'b1, {cap_op, cap_buf}, 3'b011);

    // R8: every launch was a single-cycle pulse
    check("R8 single-cycle launch", wide_pulse == 1'b0, wide_pulse, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule